// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Datapath

This block is a behavioural synchronous static RAM built from a small parameterised register array. Chip select, the write command, the write-gating strobes, the address and the write data are all captured on the rising clock edge. A captured read delivers its word at the next rising edge through an output register, together with an output-valid flag that stands in for the output drivers being on.

A write can cover the whole word or a subset of byte lanes. An active-low global write forces every lane to be written. Without it, an active-low byte write enable plus one active-low strobe per lane chooses which lanes change.

A mode input sets how long the output stays on after the block is deselected. The output can turn off one edge after the deselect is captured (single-cycle deselect) or two edges after (dual-cycle deselect). A snooze input blocks all accesses, forces the output off at once and keeps the array contents. Burst address generation happens outside the block; every cycle presents a full address.

Top module: `ssram_pipe`

## Requirements
- R1: A read is requested by `cs`=1, `wr`=0 and `snooze`=0 at a rising edge. `rvalid` rises at the following rising edge and `rdata` then carries the word stored at the captured address.
- R2: While `rst_n` is low, and after it is released until the first read completes, `rvalid` is 0.
- R3: A write is requested by `cs`=1, `wr`=1 and `snooze`=0. With `gw_n`=0 all lanes are written, whatever `bwe_n` and `bw_n` are.
- R4: A write with `gw_n`=1 and `bwe_n`=0 changes only the lanes whose `bw_n` bit is 0. Lane i is `wdata[8i+7:8i]` and is strobed by `bw_n[i]`.
- R5: A write with `gw_n`=1 and `bwe_n`=1 changes no stored byte.
- R6: With `dcd_mode`=0, a deselect captured at a rising edge turns `rvalid` off at the next rising edge. A deselect is `cs`=0 or `snooze`=1.
- R7: With `dcd_mode`=1, a deselect captured at a rising edge holds `rvalid` and `rdata` for one more edge. `rvalid` then turns off at the second rising edge after the capture.
- R8: A captured write turns `rvalid` off at the next rising edge in either mode.
- R9: While `snooze`=1, `rvalid` is 0 in the same cycle, inputs are ignored and no stored byte changes.
- R10: A write to the same address, captured at the edge after a read, does not alter that read's `rdata`. A read captured after a write returns the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| wr | input | 1 | 1 = write, 0 = read when selected |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | LANES | Per-lane write strobes, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data |
| dcd_mode | input | 1 | 0 = single-cycle deselect, 1 = dual-cycle deselect |
| snooze | input | 1 | Low-power hold, active high |
| rdata | output | LANES*LANE_W | Read data, meaningful while rvalid is 1 |
| rvalid | output | 1 | Output-on flag |

## Verification
The bench uses the default parameters: 16 words of four 8-bit lanes. With so few words, random addresses often collide. Reads therefore land on freshly written words, and writes land on words whose read is still in flight. Four lanes let the random strobe patterns cover every subset of the word. The deselect mode is also switched at random, so both turn-off lags appear after reads, writes and snooze.

// File: rtl/ssram_pkg.sv
package ssram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/ssram_in_stage.sv
module ssram_in_stage
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              wr,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              snooze,
  output op_e               op_q,
  output logic [LANES-1:0]  lane_we_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  logic             access;
  op_e              op_d;
  logic [LANES-1:0] lane_we_d;

  always_comb begin
    access    = cs & ~snooze;
    op_d      = OP_IDLE;
    lane_we_d = '0;
    if (access) begin
      if (wr) begin
        op_d = OP_WRITE;
        if (!gw_n)       lane_we_d = '1;
        else if (!bwe_n) lane_we_d = ~bw_n;
      end else begin
        op_d = OP_READ;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q      <= OP_IDLE;
      lane_we_q <= '0;
    end else begin
      op_q      <= op_d;
      lane_we_q <= lane_we_d;
    end
  end

  always_ff @(posedge clk) begin
    if (access) begin
      addr_q  <= addr;
      wdata_q <= wdata;
    end
  end

  // R3: global write reaches every lane
  a_r3_global_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && !gw_n && !snooze) |=> (lane_we_q == {LANES{1'b1}}));
  // R5: no gating asserted means nothing written
  a_r5_no_gate_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && gw_n && bwe_n && !snooze) |=> (lane_we_q == '0));
  // R9: snooze is captured as idle
  a_r9_snooze_idle: assert property (@(posedge clk) disable iff (!rst_n)
    snooze |=> (op_q == OP_IDLE && lane_we_q == '0));
endmodule

// File: rtl/ssram_array.sv
module ssram_array #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic [LANES-1:0]  lane_we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[g]) bank[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rd_word[g*LANE_W +: LANE_W] = bank[addr];
  end
endmodule

// File: rtl/ssram_out_stage.sv
module ssram_out_stage
  import ssram_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op_q,
  input  logic              dcd_mode,
  input  logic              snooze,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic oe_q, held_q;
  logic oe_d, held_d;
  logic load;

  always_comb begin
    load   = (op_q == OP_READ);
    oe_d   = load | (dcd_mode & (op_q == OP_IDLE) & oe_q & ~held_q);
    held_d = oe_d & ~load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      held_q <= 1'b0;
    end else begin
      oe_q   <= oe_d;
      held_q <= held_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) rdata <= rd_word;
  end

  assign rvalid = oe_q & ~snooze;

  // R1: a captured read turns the output on at the next edge
  a_r1_read_on: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_READ) |=> oe_q);
  // R6: single-cycle deselect
  a_r6_scd_off: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_IDLE && !dcd_mode) |=> !oe_q);
  // R7: dual-cycle deselect ends after one hold
  a_r7_dcd_off: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_IDLE && $past(op_q) == OP_IDLE && dcd_mode) |=> !oe_q);
  // R8: write turns the output off
  a_r8_write_off: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_WRITE) |=> !oe_q);
  // R7: held output keeps its data
  a_r7_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && op_q != OP_READ) |=> $stable(rdata));
endmodule

// File: rtl/ssram_pipe.sv
module ssram_pipe
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              wr,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              dcd_mode,
  input  logic              snooze,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  op_e               op_q;
  logic [LANES-1:0]  lane_we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rd_word;

  ssram_in_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_in (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .gw_n(gw_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .addr(addr), .wdata(wdata), .snooze(snooze),
    .op_q(op_q), .lane_we_q(lane_we_q), .addr_q(addr_q), .wdata_q(wdata_q)
  );

  ssram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .lane_we(lane_we_q), .addr(addr_q), .wdata(wdata_q),
    .rd_word(rd_word)
  );

  ssram_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .op_q(op_q), .dcd_mode(dcd_mode),
    .snooze(snooze), .rd_word(rd_word), .rdata(rdata), .rvalid(rvalid)
  );

  // R9: snooze silences the output in the same cycle
  a_r9_snooze_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    snooze |-> !rvalid);
endmodule

// File: tb/tb_ssram_pipe.sv
module tb_ssram_pipe;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs, wr, gw_n, bwe_n, dcd_mode, snooze;
  logic [3:0]  bw_n, addr;
  logic [31:0] wdata, rdata;
  logic        rvalid;

  int n_chk = 0, n_bad = 0;

  // reference state
  logic [31:0] m_mem [16];
  int          m_op;        // 0 idle 1 read 2 write
  logic [3:0]  m_we, m_addr;
  logic [31:0] m_wd;
  logic        e_oe, e_held;
  logic [31:0] e_data;

  ssram_pipe dut (.clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .addr(addr), .wdata(wdata),
    .dcd_mode(dcd_mode), .snooze(snooze), .rdata(rdata), .rvalid(rvalid));

  always #10 clk = ~clk;

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: act=hung exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] d, logic [3:0] we);
    for (int i = 0; i < 4; i++) if (we[i]) old[i*8 +: 8] = d[i*8 +: 8];
    return old;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // one clock cycle: drive at negedge, model the edge, compare at the next negedge
  task automatic cyc(input logic i_cs, input logic i_wr, input logic i_gw, input logic i_bwe,
                     input logic [3:0] i_bw, input logic [3:0] i_a, input logic [31:0] i_d,
                     input logic i_snz, input string req);
    logic nxt_oe;
    logic acc;
    cs = i_cs; wr = i_wr; gw_n = i_gw; bwe_n = i_bwe; bw_n = i_bw;
    addr = i_a; wdata = i_d; snooze = i_snz;
    @(posedge clk);
    nxt_oe = (m_op == 1) || (dcd_mode && m_op == 0 && e_oe && !e_held);
    e_held = nxt_oe && (m_op != 1);
    if (m_op == 1) e_data = m_mem[m_addr];
    e_oe = nxt_oe;
    m_mem[m_addr] = merge(m_mem[m_addr], m_wd, m_we);
    acc = i_cs && !i_snz;
    m_op = !acc ? 0 : (i_wr ? 2 : 1);
    m_we = (acc && i_wr) ? (!i_gw ? 4'hF : (!i_bwe ? ~i_bw : 4'h0)) : 4'h0;
    if (acc) begin m_addr = i_a; m_wd = i_d; end
    @(negedge clk);
    chk(rvalid == (e_oe && !i_snz), req, {31'd0, rvalid}, {31'd0, e_oe && !i_snz});
    if (e_oe && !i_snz) chk(rdata == e_data, req, rdata, e_data);
  endtask

  task automatic idle(input string req);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 4'd0, 32'd0, 1'b0, req);
  endtask
  task automatic rd(input logic [3:0] a, input string req);
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 4'hF, a, 32'd0, 1'b0, req);
  endtask
  task automatic wrg(input logic [3:0] a, input logic [31:0] d, input string req);
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 4'hF, a, d, 1'b0, req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cs = 0; wr = 0; gw_n = 1; bwe_n = 1; bw_n = 4'hF;
    addr = 0; wdata = 0; dcd_mode = 0; snooze = 0;
    for (int i = 0; i < 16; i++) m_mem[i] = 32'd0;
    m_op = 0; m_we = 0; m_addr = 0; m_wd = 0; e_oe = 0; e_held = 0; e_data = 0;
    repeat (3) @(negedge clk);
    chk(rvalid == 1'b0, "R2 reset", {31'd0, rvalid}, 32'd0);
    rst_n = 1'b1;
    // clear the array so the reference starts known
    for (int i = 0; i < 16; i++) wrg(i[3:0], 32'd0, "R3");
    idle("R2");
    chk(rvalid == 1'b0, "R2 after reset", {31'd0, rvalid}, 32'd0);

    // R3 global write overrides strobes; R1 read latency; R6 SCD
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 4'd1, 32'h11223344, 1'b0, "R3");
    rd(4'd1, "R1");
    chk(rvalid == 1'b0, "R1 not yet", {31'd0, rvalid}, 32'd0);
    idle("R6");
    chk(rvalid && rdata == 32'h11223344, "R1 data", rdata, 32'h11223344);
    idle("R6");
    chk(rvalid == 1'b0, "R6 scd off", {31'd0, rvalid}, 32'd0);

    // R7 DCD holds one more cycle
    dcd_mode = 1'b1;
    rd(4'd1, "R7");
    idle("R7");
    idle("R7");
    chk(rvalid && rdata == 32'h11223344, "R7 dcd hold", rdata, 32'h11223344);
    idle("R7");
    chk(rvalid == 1'b0, "R7 dcd off", {31'd0, rvalid}, 32'd0);

    // R8 write turns off even in DCD
    rd(4'd1, "R8");
    wrg(4'd5, 32'hCAFEF00D, "R8");
    idle("R8");
    chk(rvalid == 1'b0, "R8 write off", {31'd0, rvalid}, 32'd0);
    dcd_mode = 1'b0;

    // R4 byte lanes 0 and 2
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 4'b1010, 4'd2, 32'hAABBCCDD, 1'b0, "R4");
    rd(4'd2, "R4");
    idle("R4");
    chk(rdata == 32'h00BB00DD, "R4 lanes", rdata, 32'h00BB00DD);
    // R5 no gate
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 4'h0, 4'd2, 32'hFFFFFFFF, 1'b0, "R5");
    rd(4'd2, "R5");
    idle("R5");
    chk(rdata == 32'h00BB00DD, "R5 unchanged", rdata, 32'h00BB00DD);

    // R10 write right after a read to the same address
    wrg(4'd3, 32'h01010101, "R10");
    rd(4'd3, "R10");
    wrg(4'd3, 32'h02020202, "R10");
    chk(rvalid && rdata == 32'h01010101, "R10 in flight", rdata, 32'h01010101);
    rd(4'd3, "R10");
    idle("R10");
    chk(rdata == 32'h02020202, "R10 new data", rdata, 32'h02020202);

    // R9 snooze: output off at once, write blocked, data kept
    rd(4'd1, "R9");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 4'd1, 32'hDEADBEEF, 1'b1, "R9");
    chk(rvalid == 1'b0, "R9 quiet", {31'd0, rvalid}, 32'd0);
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 4'd1, 32'd0, 1'b1, "R9");
    rd(4'd1, "R9");
    idle("R9");
    chk(rdata == 32'h11223344, "R9 kept", rdata, 32'h11223344);

    // random traffic against the reference
    for (int i = 0; i < 1500; i++) begin
      if (($urandom % 50) == 0) dcd_mode = $urandom % 2;
      cyc(($urandom % 4) != 0, $urandom % 2, ($urandom % 3) != 0, $urandom % 2,
          4'($urandom), 4'($urandom), $urandom, ($urandom % 12) == 0, "R1 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule